// File: doc/BRIEF.md
# Command/Response Byte FIFO Engine

This block sequences one command and one response through a byte-wide data port, steered by a status register. A host writes command bytes one at a time. The engine stores them and reads a 32-bit big-endian length from stream bytes 2 to 5 to tell when the command is complete. The host then writes a go request, and the engine hands the stored command to a backend with a one-cycle request strobe. The backend reads the command through its own read port and writes the response into the engine's response buffer. It ends with a done strobe. The host then drains the response byte by byte and may rewind it with a retry request. It may also abort or shortcut back to the ready phase with a command-ready request.

The host port carries a locality number, and an arbiter outside the block names the active locality. Only accesses from the active locality are acted on. The status read reports a burst count. While a response is pending, the count is the number of unread response bytes. At all other times it is the free space in the command buffer. Event outputs pulse for one cycle each time the command-ready, status-valid or data-available condition is raised, so an interrupt controller outside the block can latch them.

Top module: `cmdrsp_engine`

## Requirements
- R1: After reset the engine is idle with a zero status byte and an empty command buffer. A status read returns 0x00040000 for the default depth of 1024.
- R2: A status read returns the status byte in bits 7:0, with valid at bit 7, command-ready at 6, go at 5, data-available at 4, expect at 3 and retry at 1, and the burst count from bit 8 up. The count is the response length minus the bytes already read while data-available is set, and the depth minus the stored command bytes otherwise. A byte-sized read limits the free-space count to 0xFF.
- R3: An access whose locality differs from the active one, or made while no locality is active, returns 0xFFFFFFFF on a read and changes nothing on a write.
- R4: A status write is masked to bits 6, 5 and 1. It takes effect only when exactly one of them remains set.
- R5: A command-ready request works by phase. In idle it enters ready with status 0x40 and pulses irq_cmd_ready. In ready it clears both offsets without a pulse. In reception it aborts at once to ready with status 0x40 and a pulse. In completion it returns to ready with status 0x40, and it pulses only if command-ready was clear.
- R6: A data byte written in ready enters reception with status 0x88 and is stored. Data bytes written in idle, execution or completion are discarded.
- R7: While expect is set, each byte is stored and the count advances. Once at least 6 bytes are held, expect clears when the count reaches the big-endian length in bytes 2 to 5. A byte that arrives with the buffer full is dropped and leaves status 0x80.
- R8: A go request in reception with expect clear enters execution, pulses be_req, and shows the stored byte count on be_cmd_len. In every other case it has no effect.
- R9: A done strobe in execution enters completion with status 0x90 and resets both offsets. It pulses irq_data_avail and irq_sts_valid together.
- R10: A data read returns 0x000000FF unless the engine is in completion with data-available set. In that case it returns the next response byte. Reading the byte at the response's own length leaves status 0x80 and pulses irq_sts_valid.
- R11: A retry request in completion rewinds the response to its first byte and restores status 0x90.
- R12: A command-ready request in execution pulses be_cancel. The next done strobe then returns the engine to ready with status 0x40 and pulses irq_cmd_ready, not data-available.
- R13: Read data and rd_valid appear one cycle after the read access. be_cmd_byte shows the command byte at be_cmd_addr one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_en | input | 1 | Host access strobe, one cycle per access |
| acc_wr | input | 1 | 1 write, 0 read |
| acc_fifo | input | 1 | 1 data byte register, 0 status register |
| acc_byte | input | 1 | Byte-sized access (limits the free-space count) |
| acc_loc | input | LOC_W | Locality issuing the access |
| act_loc | input | LOC_W | Active locality from the arbiter |
| act_vld | input | 1 | A locality is active |
| acc_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| irq_cmd_ready | output | 1 | Command-ready event pulse |
| irq_sts_valid | output | 1 | Status-valid event pulse |
| irq_data_avail | output | 1 | Data-available event pulse |
| be_req | output | 1 | Command handed to backend |
| be_cancel | output | 1 | Abort of the running command |
| be_done | input | 1 | Backend finished |
| be_cmd_len | output | AW+1 | Stored command byte count |
| be_cmd_addr | input | AW | Command read address |
| be_cmd_byte | output | 8 | Command byte, one cycle after address |
| be_rsp_we | input | 1 | Response byte write strobe |
| be_rsp_addr | input | AW | Response byte index |
| be_rsp_data | input | 8 | Response byte |

## Verification
Phase or offset errors show up in the status word on the very next status read. The status byte gives the phase away through its flag combination, and the burst count exposes either offset to the exact byte. A wrong length decode shows at once as expect staying set or clearing one byte early. A missed or doubled event pulse is visible in the cycle after the access that causes it. The bench therefore reads the status after each step and samples every strobe in the cycle that follows the triggering edge.

// File: rtl/cmdrsp_pkg.sv
// Shared types and constants for the command/response engine.
// Assumes a single engine per instance; status bit positions are fixed
// because host software decodes them.
package cmdrsp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READY = 3'd1,
        ST_RECV  = 3'd2,
        ST_EXEC  = 3'd3,
        ST_DONE  = 3'd4
    } eng_state_e;

    localparam int SB_VALID  = 7;
    localparam int SB_CMDRDY = 6;
    localparam int SB_GO     = 5;
    localparam int SB_DAVAIL = 4;
    localparam int SB_EXPECT = 3;
    localparam int SB_RETRY  = 1;

    localparam logic [7:0] STS_OP_MASK = 8'h62;
    localparam logic [7:0] STS_OP_CR   = 8'h40;
    localparam logic [7:0] STS_OP_GO   = 8'h20;
    localparam logic [7:0] STS_OP_RTY  = 8'h02;

    localparam logic [7:0] STS_V       = 8'h80;
    localparam logic [7:0] STS_CR      = 8'h40;
    localparam logic [7:0] STS_V_EXP   = 8'h88;
    localparam logic [7:0] STS_V_DA    = 8'h90;

    localparam int HDR_MIN = 6;
endpackage

// File: rtl/cmdrsp_bytebuf.sv
// Byte buffer with one synchronous write port and one registered read port.
// Assumes the read port may observe the write of the same edge as old data.
module cmdrsp_bytebuf #(
    parameter int DEPTH = 1024,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    // Store on write, register the byte at the read address every cycle.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/cmdrsp_lencap.sv
// Captures the 32-bit big-endian length carried in stream bytes 2..5.
// LOOKAHEAD=1 outputs the value including the byte written this cycle,
// LOOKAHEAD=0 outputs the registered value.
module cmdrsp_lencap #(
    parameter int IW = 10,
    parameter bit LOOKAHEAD = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  logic [7:0]    din,
    output logic [31:0]   len_o
);
    logic [31:0] len_q, len_n;

    // Merge an incoming header byte into its big-endian position.
    always_comb begin
        len_n = len_q;
        if (we) begin
            case (idx)
                IW'(2): len_n[31:24] = din;
                IW'(3): len_n[23:16] = din;
                IW'(4): len_n[15:8]  = din;
                IW'(5): len_n[7:0]   = din;
                default: ;
            endcase
        end
    end

    // Hold the captured length; clear on reset or new transaction.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) len_q <= '0;
        else               len_q <= len_n;
    end

    generate
        if (LOOKAHEAD) begin : g_ahead
            assign len_o = len_n;
        end else begin : g_reg
            assign len_o = len_q;
        end
    endgenerate
endmodule

// File: rtl/cmdrsp_engine.sv
// Command/response engine: phase machine, offsets, status word and
// read-data path. Assumes locality arbitration outside, response length
// not above DEPTH, and be_done only while a command executes.
module cmdrsp_engine
    import cmdrsp_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int LOC_W = 3,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_en,
    input  logic             acc_wr,
    input  logic             acc_fifo,
    input  logic             acc_byte,
    input  logic [LOC_W-1:0] acc_loc,
    input  logic [LOC_W-1:0] act_loc,
    input  logic             act_vld,
    input  logic [7:0]       acc_wdata,
    output logic             rd_valid,
    output logic [31:0]      rd_data,
    output logic             irq_cmd_ready,
    output logic             irq_sts_valid,
    output logic             irq_data_avail,
    output logic             be_req,
    output logic             be_cancel,
    input  logic             be_done,
    output logic [CW-1:0]    be_cmd_len,
    input  logic [AW-1:0]    be_cmd_addr,
    output logic [7:0]       be_cmd_byte,
    input  logic             be_rsp_we,
    input  logic [AW-1:0]    be_rsp_addr,
    input  logic [7:0]       be_rsp_data
);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    eng_state_e   state, state_n;
    logic [7:0]   sts, sts_n;
    logic [CW-1:0] w_off, w_off_n, r_off, r_off_n;
    logic         abort_pend, abort_n;
    logic         req_n, cancel_n, icr_n, isv_n, ida_n;

    logic         owner, wr_stat, wr_fifo, rd_any, rd_fifo;
    logic [7:0]   op_bits;
    logic         op_cr, op_go, op_rty;
    logic         fifo_take, expect_eff, cmd_store, rsp_pop;
    logic [31:0]  cmd_len_ahead, rsp_len;
    logic [7:0]   rsp_q;
    logic [CW-1:0] room;
    logic [23:0]  burst;
    logic [31:0]  stat_word;
    logic         rd_from_mem;
    logic [31:0]  rd_hold;

    // Decode the host access against the active locality.
    always_comb begin
        owner   = act_vld && (act_loc == acc_loc);
        wr_stat = acc_en && acc_wr && !acc_fifo && owner;
        wr_fifo = acc_en && acc_wr && acc_fifo && owner;
        rd_any  = acc_en && !acc_wr;
        rd_fifo = rd_any && acc_fifo && owner;
        op_bits = acc_wdata & STS_OP_MASK;
        op_cr   = (op_bits == STS_OP_CR);
        op_go   = (op_bits == STS_OP_GO);
        op_rty  = (op_bits == STS_OP_RTY);
    end

    // Qualify data-port writes and reads for the current phase.
    always_comb begin
        fifo_take  = wr_fifo && (state == ST_READY || state == ST_RECV);
        expect_eff = (state == ST_READY) || sts[SB_EXPECT];
        cmd_store  = fifo_take && expect_eff && (w_off < DEPTH_C);
        rsp_pop    = rd_fifo && (state == ST_DONE) && sts[SB_DAVAIL];
    end

    cmdrsp_bytebuf #(.DEPTH(DEPTH)) u_cmd_buf (
        .clk   (clk),
        .we    (cmd_store),
        .waddr (w_off[AW-1:0]),
        .wdata (acc_wdata),
        .raddr (be_cmd_addr),
        .rdata (be_cmd_byte)
    );

    cmdrsp_bytebuf #(.DEPTH(DEPTH)) u_rsp_buf (
        .clk   (clk),
        .we    (be_rsp_we),
        .waddr (be_rsp_addr),
        .wdata (be_rsp_data),
        .raddr (r_off[AW-1:0]),
        .rdata (rsp_q)
    );

    cmdrsp_lencap #(.IW(AW), .LOOKAHEAD(1'b1)) u_cmd_len (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (be_req),
        .we    (cmd_store),
        .idx   (w_off[AW-1:0]),
        .din   (acc_wdata),
        .len_o (cmd_len_ahead)
    );

    cmdrsp_lencap #(.IW(AW), .LOOKAHEAD(1'b0)) u_rsp_len (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (be_req),
        .we    (be_rsp_we),
        .idx   (be_rsp_addr),
        .din   (be_rsp_data),
        .len_o (rsp_len)
    );

    // Next phase, status, offsets and event strobes.
    always_comb begin
        state_n  = state;
        sts_n    = sts;
        w_off_n  = w_off;
        r_off_n  = r_off;
        abort_n  = abort_pend;
        req_n    = 1'b0;
        cancel_n = 1'b0;
        icr_n    = 1'b0;
        isv_n    = 1'b0;
        ida_n    = 1'b0;
        if (be_done && state == ST_EXEC) begin
            w_off_n = '0;
            r_off_n = '0;
            if (abort_pend) begin
                state_n = ST_READY;
                sts_n   = STS_CR;
                abort_n = 1'b0;
                icr_n   = 1'b1;
            end else begin
                state_n = ST_DONE;
                sts_n   = STS_V_DA;
                ida_n   = 1'b1;
                isv_n   = 1'b1;
            end
        end else if (wr_stat) begin
            if (op_cr) begin
                case (state)
                    ST_IDLE: begin
                        state_n = ST_READY;
                        sts_n   = STS_CR;
                        icr_n   = 1'b1;
                    end
                    ST_READY: begin
                        w_off_n = '0;
                        r_off_n = '0;
                    end
                    ST_RECV: begin
                        w_off_n = '0;
                        r_off_n = '0;
                        state_n = ST_READY;
                        sts_n   = STS_CR;
                        icr_n   = 1'b1;
                    end
                    ST_EXEC: begin
                        if (!abort_pend) begin
                            abort_n  = 1'b1;
                            cancel_n = 1'b1;
                        end
                    end
                    ST_DONE: begin
                        w_off_n = '0;
                        r_off_n = '0;
                        state_n = ST_READY;
                        icr_n   = !sts[SB_CMDRDY];
                        sts_n   = STS_CR;
                    end
                    default: ;
                endcase
            end else if (op_go) begin
                if (state == ST_RECV && !sts[SB_EXPECT]) begin
                    state_n = ST_EXEC;
                    req_n   = 1'b1;
                end
            end else if (op_rty) begin
                if (state == ST_DONE) begin
                    r_off_n = '0;
                    sts_n   = STS_V_DA;
                end
            end
        end else if (fifo_take) begin
            if (state == ST_READY) begin
                state_n = ST_RECV;
                sts_n   = STS_V_EXP;
            end
            if (sts_n[SB_EXPECT]) begin
                if (cmd_store) w_off_n = w_off + 1'b1;
                else           sts_n   = STS_V;
            end
            if (sts_n[SB_EXPECT] && w_off_n >= CW'(HDR_MIN)) begin
                sts_n = (cmd_len_ahead > 32'(w_off_n)) ? STS_V_EXP : STS_V;
            end
        end else if (rsp_pop) begin
            r_off_n = r_off + 1'b1;
            if (32'(r_off_n) >= rsp_len) begin
                sts_n = STS_V;
                isv_n = 1'b1;
            end
        end
    end

    // Register the phase machine and its strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state          <= ST_IDLE;
            sts            <= '0;
            w_off          <= '0;
            r_off          <= '0;
            abort_pend     <= 1'b0;
            be_req         <= 1'b0;
            be_cancel      <= 1'b0;
            irq_cmd_ready  <= 1'b0;
            irq_sts_valid  <= 1'b0;
            irq_data_avail <= 1'b0;
        end else begin
            state          <= state_n;
            sts            <= sts_n;
            w_off          <= w_off_n;
            r_off          <= r_off_n;
            abort_pend     <= abort_n;
            be_req         <= req_n;
            be_cancel      <= cancel_n;
            irq_cmd_ready  <= icr_n;
            irq_sts_valid  <= isv_n;
            irq_data_avail <= ida_n;
        end
    end

    // Build the status word with the phase-dependent burst count.
    always_comb begin
        room = DEPTH_C - w_off;
        if (sts[SB_DAVAIL])
            burst = rsp_len[23:0] - 24'(r_off);
        else if (acc_byte && room > CW'(255))
            burst = 24'hFF;
        else
            burst = 24'(room);
        stat_word = {burst, sts};
    end

    // Register read results; response bytes come straight from the buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid    <= 1'b0;
            rd_from_mem <= 1'b0;
            rd_hold     <= '0;
        end else begin
            rd_valid    <= rd_any;
            rd_from_mem <= rsp_pop;
            if (!owner)        rd_hold <= 32'hFFFF_FFFF;
            else if (acc_fifo) rd_hold <= 32'h0000_00FF;
            else               rd_hold <= stat_word;
        end
    end

    assign rd_data    = rd_from_mem ? {24'h0, rsp_q} : rd_hold;
    assign be_cmd_len = w_off;
endmodule

// File: rtl/cmdrsp_engine_chk.sv
// Property checker for cmdrsp_engine, attached by bind below.
// Assumes the internal phase, status byte and write offset are visible.
module cmdrsp_engine_chk
    import cmdrsp_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int LOC_W = 3,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_en,
    input logic             acc_wr,
    input logic [LOC_W-1:0] acc_loc,
    input logic [LOC_W-1:0] act_loc,
    input logic             act_vld,
    input logic             rd_valid,
    input logic [31:0]      rd_data,
    input logic             be_done,
    input logic             be_req,
    input logic             be_cancel,
    input logic             irq_sts_valid,
    input logic             irq_data_avail,
    input eng_state_e       state,
    input logic [7:0]       sts,
    input logic [CW-1:0]    w_off
);
    // R3
    foreign_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_wr && !(act_vld && act_loc == acc_loc))
        |=> (rd_valid && rd_data == 32'hFFFF_FFFF));

    // R9
    da_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_data_avail |-> $past(be_done));

    // R8
    go_from_recv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        be_req |-> (state == ST_EXEC && $past(state) == ST_RECV));

    // R7
    wr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        w_off <= CW'(DEPTH));

    // R10
    last_byte_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_sts_valid && !irq_data_avail) |-> (sts == 8'h80));

    // R12
    cancel_in_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        be_cancel |-> (state == ST_EXEC));
endmodule

bind cmdrsp_engine cmdrsp_engine_chk #(.DEPTH(DEPTH), .LOC_W(LOC_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .acc_en         (acc_en),
    .acc_wr         (acc_wr),
    .acc_loc        (acc_loc),
    .act_loc        (act_loc),
    .act_vld        (act_vld),
    .rd_valid       (rd_valid),
    .rd_data        (rd_data),
    .be_done        (be_done),
    .be_req         (be_req),
    .be_cancel      (be_cancel),
    .irq_sts_valid  (irq_sts_valid),
    .irq_data_avail (irq_data_avail),
    .state          (state),
    .sts            (sts),
    .w_off          (w_off)
);

// File: tb/tb_cmdrsp_engine.sv
`timescale 1ns/1ps
// Scoreboard bench: read tasks queue expected words, a monitor compares.
module tb_cmdrsp_engine;
    localparam int DEPTH = 1024;
    localparam int LOC_W = 3;
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_en = 1'b0, acc_wr = 1'b0, acc_fifo = 1'b0, acc_byte = 1'b0;
    logic [LOC_W-1:0] acc_loc = '0, act_loc = '0;
    logic act_vld = 1'b1;
    logic [7:0] acc_wdata = '0;
    logic rd_valid;
    logic [31:0] rd_data;
    logic irq_cmd_ready, irq_sts_valid, irq_data_avail, be_req, be_cancel;
    logic be_done = 1'b0;
    logic [CW-1:0] be_cmd_len;
    logic [AW-1:0] be_cmd_addr = '0;
    logic [7:0] be_cmd_byte;
    logic be_rsp_we = 1'b0;
    logic [AW-1:0] be_rsp_addr = '0;
    logic [7:0] be_rsp_data = '0;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] exp_q[$];
    string tag_q[$];
    logic c_cr, c_sv, c_da, c_req, c_cancel;

    always #2.5 clk = ~clk;

    cmdrsp_engine #(.DEPTH(DEPTH), .LOC_W(LOC_W)) dut (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // Monitor: compare each returned read with the queued expectation.
    always @(negedge clk) begin
        if (rd_valid) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R13: unexpected read data %08h expected none", rd_data);
            end else begin
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    task automatic access(input bit wr, input bit fifo, input bit bsz,
                          input logic [LOC_W-1:0] loc, input logic [7:0] wd);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = wr; acc_fifo = fifo; acc_byte = bsz;
        acc_loc = loc; acc_wdata = wd;
        @(negedge clk);
        acc_en = 1'b0;
        c_cr = irq_cmd_ready; c_sv = irq_sts_valid; c_da = irq_data_avail;
        c_req = be_req; c_cancel = be_cancel;
    endtask

    task automatic rd_stat(input logic [31:0] exp, input string tag, input bit bsz = 1'b0,
                           input logic [LOC_W-1:0] loc = '0);
        exp_q.push_back(exp); tag_q.push_back(tag);
        access(1'b0, 1'b0, bsz, loc, 8'h00);
    endtask

    task automatic rd_fifo(input logic [31:0] exp, input string tag,
                           input logic [LOC_W-1:0] loc = '0);
        exp_q.push_back(exp); tag_q.push_back(tag);
        access(1'b0, 1'b1, 1'b0, loc, 8'h00);
    endtask

    task automatic wr_stat(input logic [7:0] v, input logic [LOC_W-1:0] loc = '0);
        access(1'b1, 1'b0, 1'b0, loc, v);
    endtask

    task automatic wr_fifo(input logic [7:0] v, input logic [LOC_W-1:0] loc = '0);
        access(1'b1, 1'b1, 1'b0, loc, v);
    endtask

    // Backend model: load response bytes, then strobe done.
    task automatic be_respond(input logic [7:0] bytes[], input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            be_rsp_we = 1'b1; be_rsp_addr = AW'(i); be_rsp_data = bytes[i];
        end
        @(negedge clk);
        be_rsp_we = 1'b0; be_done = 1'b1;
        @(negedge clk);
        be_done = 1'b0;
        c_cr = irq_cmd_ready; c_sv = irq_sts_valid; c_da = irq_data_avail;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] cmd[] = '{8'h00, 8'hC1, 8'h00, 8'h00, 8'h00, 8'h0A,
                              8'h11, 8'h22, 8'h33, 8'h44};
        logic [7:0] rsp[] = '{8'h80, 8'h01, 8'h00, 8'h00, 8'h00, 8'h08,
                              8'hAA, 8'hBB};
        logic [7:0] none[] = '{8'h00};
        logic [7:0] hdr6[] = '{8'h00, 8'hC1, 8'h00, 8'h00, 8'h00, 8'h06};
        logic [7:0] big[] = '{8'h00, 8'hC1, 8'hFF, 8'hFF, 8'hFF, 8'hFF};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1, R2: reset status word and byte-sized clamp
        rd_stat(32'h0004_0000, "R1 reset status");
        rd_stat(32'h0000_FF00, "R2 byte read clamp", 1'b1);

        // R6: data byte in idle discarded
        wr_fifo(8'h5A);
        rd_stat(32'h0004_0000, "R6 idle byte dropped");

        // R4: two command bits together are ignored
        wr_stat(8'h60);
        check("R4 no cmd-ready pulse", {31'h0, c_cr}, 32'h0);
        rd_stat(32'h0004_0000, "R4 multi-bit write ignored");

        // R5: command-ready in idle, then again in ready
        wr_stat(8'h40);
        check("R5 idle cmd-ready pulse", {31'h0, c_cr}, 32'h1);
        rd_stat(32'h0004_0040, "R5 ready status");
        wr_stat(8'h40);
        check("R5 ready no pulse", {31'h0, c_cr}, 32'h0);
        rd_stat(32'h0000_FF40, "R2 ready byte clamp", 1'b1);

        // R3: foreign locality reads all ones and writes nothing
        rd_stat(32'hFFFF_FFFF, "R3 foreign status read", 1'b0, 3'd1);
        rd_fifo(32'hFFFF_FFFF, "R3 foreign fifo read", 3'd1);
        wr_fifo(8'h00, 3'd1);
        wr_stat(8'h40, 3'd1);
        rd_stat(32'h0004_0040, "R3 foreign writes ignored");

        // R6, R7: command reception and length parse
        wr_fifo(cmd[0]);
        rd_stat(32'h0003_FF88, "R6 reception entered");
        for (int i = 1; i < 6; i++) wr_fifo(cmd[i]);
        rd_stat(32'h0003_FA88, "R7 expect held at 6 of 10");
        wr_stat(8'h20);
        check("R8 go ignored while expect", {31'h0, c_req}, 32'h0);
        rd_stat(32'h0003_FA88, "R8 state kept");
        for (int i = 6; i < 10; i++) wr_fifo(cmd[i]);
        rd_stat(32'h0003_F680, "R7 command complete");

        // R8, R13: go and backend command read port
        wr_stat(8'h20);
        check("R8 be_req pulse", {31'h0, c_req}, 32'h1);
        check("R8 be_cmd_len", 32'(be_cmd_len), 32'd10);
        @(negedge clk); be_cmd_addr = AW'(1);
        @(negedge clk);
        check("R13 command read port", {24'h0, be_cmd_byte}, 32'h0000_00C1);

        // R10, R6: execution ignores data port
        rd_fifo(32'h0000_00FF, "R10 fifo read in execution");
        wr_fifo(8'h77);
        rd_stat(32'h0003_F680, "R6 byte dropped in execution");

        // R9: backend completes
        be_respond(rsp, 8);
        check("R9 data-avail pulse", {31'h0, c_da}, 32'h1);
        check("R9 sts-valid pulse", {31'h0, c_sv}, 32'h1);
        rd_stat(32'h0000_0890, "R9 completion status");

        // R10, R11: partial drain, retry, full drain
        rd_fifo(32'h80, "R10 byte 0");
        rd_fifo(32'h01, "R10 byte 1");
        rd_fifo(32'h00, "R10 byte 2");
        rd_stat(32'h0000_0590, "R2 unread count");
        wr_stat(8'h02);
        rd_stat(32'h0000_0890, "R11 retry restores");
        for (int i = 0; i < 7; i++) rd_fifo({24'h0, rsp[i]}, "R11 replay byte");
        check("R10 no early sts-valid", {31'h0, c_sv}, 32'h0);
        rd_fifo({24'h0, rsp[7]}, "R10 last byte");
        check("R10 last byte pulse", {31'h0, c_sv}, 32'h1);
        rd_stat(32'h0004_0080, "R10 drained status");
        rd_fifo(32'h0000_00FF, "R10 read past end");

        // R5: completion shortcut to ready
        wr_stat(8'h40);
        check("R5 completion pulse", {31'h0, c_cr}, 32'h1);
        rd_stat(32'h0004_0040, "R5 completion to ready");

        // R5: abort during reception
        for (int i = 0; i < 3; i++) wr_fifo(cmd[i]);
        rd_stat(32'h0003_FD88, "R6 three bytes held");
        wr_stat(8'h40);
        check("R5 reception abort pulse", {31'h0, c_cr}, 32'h1);
        rd_stat(32'h0004_0040, "R5 reception abort");

        // R12: abort during execution
        for (int i = 0; i < 6; i++) wr_fifo(hdr6[i]);
        rd_stat(32'h0003_FA80, "R7 six-byte command complete");
        wr_stat(8'h20);
        check("R8 second go", {31'h0, c_req}, 32'h1);
        wr_stat(8'h40);
        check("R12 cancel pulse", {31'h0, c_cancel}, 32'h1);
        rd_stat(32'h0003_FA80, "R12 still executing");
        be_respond(none, 0);
        check("R12 cmd-ready pulse", {31'h0, c_cr}, 32'h1);
        check("R12 no data-avail", {31'h0, c_da}, 32'h0);
        rd_stat(32'h0004_0040, "R12 back to ready");

        // R7: buffer full handling
        for (int i = 0; i < DEPTH; i++) wr_fifo(i < 6 ? big[i] : 8'h00);
        rd_stat(32'h0000_0088, "R7 buffer full expect");
        wr_fifo(8'hEE);
        rd_stat(32'h0000_0080, "R7 overflow clears expect");
        wr_stat(8'h20);
        check("R8 go after overflow", {31'h0, c_req}, 32'h1);

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_chk++; n_bad++;
            $display("FAIL R13: actual %0d reads missing expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule